// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that finishes one instruction in every clock cycle. It fetches a word from an on-block instruction ROM at the current program counter and decodes it. It reads two operands from a 32-entry register file and computes a result. In the same cycle it either writes the result back, stores a word into a 32-word data RAM, or redirects the program counter. It supports seven instructions: two register-register arithmetic operations (add and subtract without overflow traps), an OR with an immediate, a load-upper-immediate, a word load, a word store and a branch-if-equal.

The load-upper value comes from a dedicated shift-by-16 unit and not from the ALU. Two multiplexers form the write-back value, one after the other. The first picks the shifter or the ALU. The second picks that value or the word read from the data RAM. The ROM contents are placed into the ROM array directly by the surrounding environment. The only block outputs are debug observation pins: the current PC, a register-write strobe with its index and value, and a memory-write strobe with its byte address and value. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. Every output is a plain level that describes the instruction being executed in the current cycle.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 from the next clock edge on and both write strobes are low. After reset, every register and every data RAM word reads as zero.
- R2: The PC is always a multiple of 4 and advances by 4 on every non-branch instruction. The instruction word is taken from a 64-entry ROM at index PC[7:2].
- R3: Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Opcode 0x00 with funct 0x21 writes rs+rt to rd. Funct 0x23 writes rs-rt to rd. Both wrap modulo 2^32.
- R4: Opcode 0x0D ORs rs with the zero-extended 16-bit immediate and writes the result to rt.
- R5: Opcode 0x0F writes the 16-bit immediate shifted left by 16, with zero low half, to rt.
- R6: Opcode 0x2B stores rt to the byte address rs + sign-extended immediate. The store raises the memory strobe and shows that address and data. The word slot is address bits [6:2], so bits [1:0] and bits above 6 are ignored.
- R7: Opcode 0x23 writes to rt the RAM word at slot [6:2] of rs + sign-extended immediate.
- R8: Opcode 0x04 writes nothing. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate times 4. Otherwise the next PC is PC+4.
- R9: Register 0 reads as zero. An instruction whose destination is register 0 leaves the write strobe low and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | High when this instruction writes a register |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Value written back |
| dm_we_o | output | 1 | High when this instruction stores a word |
| dm_addr_o | output | 32 | Byte address computed for load/store |
| dm_wdata_o | output | 32 | Word being stored |

## Verification
The assertions assume that `rst` is held high from time zero until the ROM image has been loaded. They also assume that the ROM holds only the seven supported encodings, plus all-zero words that decode to no operation. The bench writes the ROM only while reset is asserted and builds every word through encoder functions for those seven formats. It steers the branches so that every taken target lands on a loaded, word-aligned entry inside the 64-entry ROM.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LUI  = 6'h0F;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  // first-stage ALU class chosen by opcode
  typedef enum logic [1:0] {
    CLS_ADD,
    CLS_SUB,
    CLS_OR,
    CLS_BYFUNCT
  } alu_class_e;

  // resolved ALU operation
  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_OR
  } alu_fn_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    imm_zext;
    logic    b_from_imm;
    logic    pick_shift;
    logic    pick_mem;
    logic    mem_we;
    logic    is_branch;
    alu_fn_e alu_fn;
  } ctrl_t;

endpackage

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter int XLEN      = 32,
  parameter int ROM_DEPTH = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_br,
  input  logic [XLEN-1:0] br_off,
  output logic [XLEN-1:0] pc,
  output logic [31:0]     instr
);
  localparam int AW = $clog2(ROM_DEPTH);

  logic [31:0]     rom_mem [ROM_DEPTH];
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] nxt_pc;
  logic            unused_pc_bits;

  // ROM starts blank; the environment fills it while reset is held
  initial begin
    for (int i = 0; i < ROM_DEPTH; i++) rom_mem[i] = 32'h0;
  end

  assign seq_pc = pc_q + XLEN'(4);
  assign nxt_pc = take_br ? (seq_pc + br_off) : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= nxt_pc;
  end

  assign pc    = pc_q;
  assign instr = rom_mem[pc_q[AW+1:2]];

  assign unused_pc_bits = ^{pc_q[XLEN-1:AW+2], pc_q[1:0]};
endmodule

// File: rtl/reg_file.sv
module reg_file #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [$clog2(NREG)-1:0] ra_a,
  input  logic [$clog2(NREG)-1:0] ra_b,
  output logic [XLEN-1:0]         rd_a,
  output logic [XLEN-1:0]         rd_b
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/data_ram.sv
module data_ram #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  localparam int IW = $clog2(DEPTH);

  logic [XLEN-1:0] mem [DEPTH];
  logic [IW-1:0]   slot;
  logic            unused_addr_bits;

  // byte address -> word slot: drop the two byte-select bits
  assign slot = addr[IW+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[slot] <= wdata;
    end
  end

  assign rdata = mem[slot];

  assign unused_addr_bits = ^{addr[XLEN-1:IW+2], addr[1:0]};
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  ctrl_t      base;
  alu_class_e cls;

  // stage 1: opcode -> datapath controls and ALU class
  always_comb begin
    base = '0;
    cls  = CLS_ADD;
    unique case (opcode)
      OPC_REG: begin
        base.reg_we    = 1'b1;
        base.dst_is_rd = 1'b1;
        cls            = CLS_BYFUNCT;
      end
      OPC_ORI: begin
        base.reg_we     = 1'b1;
        base.b_from_imm = 1'b1;
        base.imm_zext   = 1'b1;
        cls             = CLS_OR;
      end
      OPC_LUI: begin
        base.reg_we     = 1'b1;
        base.pick_shift = 1'b1;
      end
      OPC_LW: begin
        base.reg_we     = 1'b1;
        base.b_from_imm = 1'b1;
        base.pick_mem   = 1'b1;
      end
      OPC_SW: begin
        base.b_from_imm = 1'b1;
        base.mem_we     = 1'b1;
      end
      OPC_BEQ: begin
        base.is_branch = 1'b1;
        cls            = CLS_SUB;
      end
      default: ;
    endcase
  end

  // stage 2: class + funct -> ALU operation
  always_comb begin
    ctrl = base;
    unique case (cls)
      CLS_ADD: ctrl.alu_fn = ALU_ADD;
      CLS_SUB: ctrl.alu_fn = ALU_SUB;
      CLS_OR:  ctrl.alu_fn = ALU_OR;
      default: begin
        unique case (funct)
          FN_ADDU: ctrl.alu_fn = ALU_ADD;
          FN_SUBU: ctrl.alu_fn = ALU_SUB;
          default: begin
            ctrl.alu_fn = ALU_ADD;
            ctrl.reg_we = 1'b0;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/mini_core.sv
module mini_core
  import core_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int ROM_DEPTH = 64,
  parameter int RAM_DEPTH = 32,
  parameter int NREG      = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o
);
  localparam int RW  = $clog2(NREG);
  localparam int IMW = 16;

  logic [31:0]     instr_w;
  logic [XLEN-1:0] pc_w;
  ctrl_t           ctl;

  logic [5:0]      f_op, f_fn;
  logic [RW-1:0]   f_rs, f_rt, f_rd;
  logic [IMW-1:0]  f_imm;
  logic            unused_shamt;

  logic [XLEN-1:0] opa, opb_reg, opb;
  logic [XLEN-1:0] imm_sx, imm_zx, imm_ext;
  logic [XLEN-1:0] alu_y, shift_y, pick1_y, wb_y;
  logic [XLEN-1:0] ram_q;
  logic [RW-1:0]   dst;
  logic            wr_go, st_go, br_take;

  assign f_op  = instr_w[31:26];
  assign f_rs  = instr_w[25:21];
  assign f_rt  = instr_w[20:16];
  assign f_rd  = instr_w[15:11];
  assign f_imm = instr_w[15:0];
  assign f_fn  = instr_w[5:0];
  assign unused_shamt = ^instr_w[10:6];

  fetch_unit #(.XLEN(XLEN), .ROM_DEPTH(ROM_DEPTH)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .take_br (br_take),
    .br_off  (imm_sx << 2),
    .pc      (pc_w),
    .instr   (instr_w)
  );

  ctrl_decode u_ctrl (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctl)
  );

  reg_file #(.XLEN(XLEN), .NREG(NREG)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .waddr (dst),
    .wdata (wb_y),
    .ra_a  (f_rs),
    .ra_b  (f_rt),
    .rd_a  (opa),
    .rd_b  (opb_reg)
  );

  // immediate forms
  assign imm_sx  = {{(XLEN-IMW){f_imm[IMW-1]}}, f_imm};
  assign imm_zx  = {{(XLEN-IMW){1'b0}}, f_imm};
  assign imm_ext = ctl.imm_zext ? imm_zx : imm_sx;
  assign opb     = ctl.b_from_imm ? imm_ext : opb_reg;

  // ALU
  always_comb begin
    unique case (ctl.alu_fn)
      ALU_SUB: alu_y = opa - opb;
      ALU_OR:  alu_y = opa | opb;
      default: alu_y = opa + opb;
    endcase
  end

  // dedicated upper-immediate shifter
  assign shift_y = imm_zx << IMW;

  data_ram #(.XLEN(XLEN), .DEPTH(RAM_DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (st_go),
    .addr  (alu_y),
    .wdata (opb_reg),
    .rdata (ram_q)
  );

  // write-back: shifter/ALU select, then memory select
  assign pick1_y = ctl.pick_shift ? shift_y : alu_y;
  assign wb_y    = ctl.pick_mem ? ram_q : pick1_y;

  assign dst     = ctl.dst_is_rd ? f_rd : f_rt;
  assign wr_go   = ctl.reg_we && (dst != '0) && !rst;
  assign st_go   = ctl.mem_we && !rst;
  assign br_take = ctl.is_branch && (opa == opb_reg);

  assign pc_o       = pc_w;
  assign rf_we_o    = wr_go;
  assign rf_waddr_o = 5'(dst);
  assign rf_wdata_o = wb_y;
  assign dm_we_o    = st_go;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = opb_reg;
endmodule

// File: rtl/core_checker.sv
module core_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_o,
  input logic            rf_we_o,
  input logic [4:0]      rf_waddr_o,
  input logic            dm_we_o,
  input logic [31:0]     instr
);
  // R1: synchronous reset forces PC to zero
  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (pc_o == '0));

  // R1: no write strobes while reset is high
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (!rf_we_o && !dm_we_o));

  // R2: PC stays word aligned
  p_pc_align_r2: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);

  // R2: sequential step of 4 for anything but a branch
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != 6'h04) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  // R8: branches write neither registers nor memory
  p_beq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h04) |-> (!rf_we_o && !dm_we_o));

  // R9: a visible register write never targets register 0
  p_no_zero_dest_r9: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_waddr_o != 5'd0));

  // R6: a store never writes a register in the same cycle
  p_store_excl_r6: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> !rf_we_o);
endmodule

bind mini_core core_checker #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc_o       (pc_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .dm_we_o    (dm_we_o),
  .instr      (instr_w)
);

// File: tb/mini_core_test.sv
module mini_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  int applied = 0;
  int fails   = 0;

  typedef struct {
    logic [31:0] pc;
    logic        rwe;
    logic [4:0]  rwa;
    logic [31:0] rwd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] mwd;
    string       tag;
  } step_t;

  step_t sb_q[$];

  always #10 clk = ~clk;

  mini_core uut (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .dm_we_o    (dm_we_o),
    .dm_addr_o  (dm_addr_o),
    .dm_wdata_o (dm_wdata_o)
  );

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rs, int rt, int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic expect_step(logic [31:0] pc, logic rwe, logic [4:0] rwa, logic [31:0] rwd,
                             logic mwe, logic [31:0] ma, logic [31:0] mwd, string tag);
    step_t s;
    s.pc = pc; s.rwe = rwe; s.rwa = rwa; s.rwd = rwd;
    s.mwe = mwe; s.ma = ma; s.mwd = mwd; s.tag = tag;
    sb_q.push_back(s);
  endtask

  task automatic wipe_rom();
    for (int i = 0; i < 64; i++) uut.u_fetch.rom_mem[i] = 32'h0;
  endtask

  task automatic check_reset_state(string tag);
    applied++;
    if (pc_o !== 32'h0 || rf_we_o !== 1'b0 || dm_we_o !== 1'b0) begin
      fails++;
      $display("FAIL %s reset: pc=%h rwe=%b mwe=%b expected pc=0 rwe=0 mwe=0",
               tag, pc_o, rf_we_o, dm_we_o);
    end
  endtask

  // monitor: compare each executed instruction against the scoreboard
  always @(negedge clk) begin
    if (!rst && sb_q.size() != 0) begin
      step_t e;
      logic  bad;
      e = sb_q.pop_front();
      applied++;
      bad = (pc_o !== e.pc) || (rf_we_o !== e.rwe) || (dm_we_o !== e.mwe);
      if (e.rwe && ((rf_waddr_o !== e.rwa) || (rf_wdata_o !== e.rwd))) bad = 1'b1;
      if (e.mwe && ((dm_addr_o !== e.ma) || (dm_wdata_o !== e.mwd))) bad = 1'b1;
      if (bad) begin
        fails++;
        $display("FAIL %s: got pc=%h rwe=%b r%0d=%h mwe=%b [%h]=%h expected pc=%h rwe=%b r%0d=%h mwe=%b [%h]=%h",
                 e.tag, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, dm_we_o, dm_addr_o, dm_wdata_o,
                 e.pc, e.rwe, e.rwa, e.rwd, e.mwe, e.ma, e.mwd);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    #5;
    // program 1 loaded while reset is held
    wipe_rom();
    uut.u_fetch.rom_mem[0]  = enc_i(6'h0F, 0, 1, 16'h1234);   // lui r1
    uut.u_fetch.rom_mem[1]  = enc_i(6'h0D, 1, 1, 16'h5678);   // ori r1
    uut.u_fetch.rom_mem[2]  = enc_i(6'h0D, 0, 2, 16'h8000);   // ori r2 (zero-ext)
    uut.u_fetch.rom_mem[3]  = enc_r(6'h21, 1, 2, 3);          // addu r3
    uut.u_fetch.rom_mem[4]  = enc_r(6'h23, 2, 1, 4);          // subu r4
    uut.u_fetch.rom_mem[5]  = enc_i(6'h2B, 0, 3, 16'h0008);   // sw r3,8(r0)
    uut.u_fetch.rom_mem[6]  = enc_i(6'h0D, 0, 5, 16'h0010);   // ori r5
    uut.u_fetch.rom_mem[7]  = enc_i(6'h2B, 5, 1, 16'hFFFC);   // sw r1,-4(r5)
    uut.u_fetch.rom_mem[8]  = enc_i(6'h23, 0, 6, 16'h0008);   // lw r6
    uut.u_fetch.rom_mem[9]  = enc_i(6'h23, 0, 7, 16'h000C);   // lw r7
    uut.u_fetch.rom_mem[10] = enc_i(6'h2B, 0, 2, 16'h0004);   // sw r2,4(r0)
    uut.u_fetch.rom_mem[11] = enc_i(6'h23, 0, 9, 16'h0007);   // lw r9,7(r0)
    uut.u_fetch.rom_mem[12] = enc_r(6'h21, 1, 1, 0);          // addu r0
    uut.u_fetch.rom_mem[13] = enc_r(6'h21, 0, 6, 8);          // addu r8,r0,r6
    uut.u_fetch.rom_mem[14] = enc_i(6'h04, 6, 3, 16'h0002);   // beq taken
    uut.u_fetch.rom_mem[15] = enc_i(6'h0D, 0, 11, 16'h0001);  // skipped
    uut.u_fetch.rom_mem[16] = enc_i(6'h0D, 0, 11, 16'h0002);  // skipped
    uut.u_fetch.rom_mem[17] = enc_i(6'h04, 1, 2, 16'h0005);   // beq not taken
    uut.u_fetch.rom_mem[18] = enc_i(6'h0F, 0, 10, 16'hFFFF);  // lui r10
    uut.u_fetch.rom_mem[19] = enc_i(6'h04, 0, 0, 16'hFFFE);   // beq back

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1");

    expect_step(32'd0,  1, 1,  32'h12340000, 0, 0, 0, "R5 lui");
    expect_step(32'd4,  1, 1,  32'h12345678, 0, 0, 0, "R4 ori");
    expect_step(32'd8,  1, 2,  32'h00008000, 0, 0, 0, "R4 ori zero-extend");
    expect_step(32'd12, 1, 3,  32'h1234D678, 0, 0, 0, "R3 addu");
    expect_step(32'd16, 1, 4,  32'hEDCC2988, 0, 0, 0, "R3 subu wrap");
    expect_step(32'd20, 0, 0,  0, 1, 32'h8, 32'h1234D678, "R6 sw");
    expect_step(32'd24, 1, 5,  32'h00000010, 0, 0, 0, "R4 ori");
    expect_step(32'd28, 0, 0,  0, 1, 32'hC, 32'h12345678, "R6 sw negative offset");
    expect_step(32'd32, 1, 6,  32'h1234D678, 0, 0, 0, "R7 lw");
    expect_step(32'd36, 1, 7,  32'h12345678, 0, 0, 0, "R7 lw");
    expect_step(32'd40, 0, 0,  0, 1, 32'h4, 32'h00008000, "R6 sw");
    expect_step(32'd44, 1, 9,  32'h00008000, 0, 0, 0, "R6 slot from bits 6:2");
    expect_step(32'd48, 0, 0,  0, 0, 0, 0, "R9 write to r0");
    expect_step(32'd52, 1, 8,  32'h1234D678, 0, 0, 0, "R9 r0 reads zero");
    expect_step(32'd56, 0, 0,  0, 0, 0, 0, "R8 beq taken");
    expect_step(32'd68, 0, 0,  0, 0, 0, 0, "R8 beq not taken");
    expect_step(32'd72, 1, 10, 32'hFFFF0000, 0, 0, 0, "R5 lui");
    expect_step(32'd76, 0, 0,  0, 0, 0, 0, "R8 beq backward");
    expect_step(32'd72, 1, 10, 32'hFFFF0000, 0, 0, 0, "R8 backward target");
    expect_step(32'd76, 0, 0,  0, 0, 0, 0, "R2 loop");

    @(posedge clk); #2 rst = 1'b0;
    wait (sb_q.size() == 0);

    // reset mid-run, then program 2 observes cleared state
    @(posedge clk); #2 rst = 1'b1;
    wipe_rom();
    uut.u_fetch.rom_mem[0] = enc_r(6'h21, 3, 0, 11);          // addu r11,r3,r0
    uut.u_fetch.rom_mem[1] = enc_i(6'h23, 0, 12, 16'h0008);   // lw r12,8(r0)
    uut.u_fetch.rom_mem[2] = enc_i(6'h0D, 0, 13, 16'h00FF);   // ori r13
    uut.u_fetch.rom_mem[3] = enc_i(6'h04, 0, 0, 16'hFFFF);    // beq self
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1 mid-run");

    expect_step(32'd0,  1, 11, 32'h0, 0, 0, 0, "R1 registers cleared");
    expect_step(32'd4,  1, 12, 32'h0, 0, 0, 0, "R1 memory cleared");
    expect_step(32'd8,  1, 13, 32'h000000FF, 0, 0, 0, "R4 ori");
    expect_step(32'd12, 0, 0,  0, 0, 0, 0, "R8 beq self");
    expect_step(32'd12, 0, 0,  0, 0, 0, 0, "R2 R8 self loop");

    @(posedge clk); #2 rst = 1'b0;
    wait (sb_q.size() == 0);
    @(posedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule